// File: doc/BRIEF.md
# Serial Bit-Access Secure Memory Controller

This block fronts a 192-bit nonvolatile store, modelled as a register array of 24 bytes. A host reaches it one bit at a time through a single address pointer and a small command set. One command clears the pointer. One advances the pointer and returns the bit it now points at. One sets the bit under the pointer. One clears the whole byte that holds the pointer. Commands arrive as single-cycle, active-high strobes on the system clock.

A one-time fuse bit, reached at pointer value 260, selects the rule set. While the fuse is intact the block is in issuer mode, and every bit and byte of the store may be written or cleared. Once the fuse is blown the block is in user mode. In user mode only the counter window (bits 64 to 111) accepts programming and byte clearing, and every other region is read-only. Each accepted program, erase or fuse blow holds a busy flag for a parameterised number of cycles. The block ignores every command while that flag is up. A disallowed write or clear is dropped without effect and latches a sticky violation flag.

Top module: `bitser_secmem`

## Requirements
- R1: After rstN is released, curAddr is 0, and dataOut, busy, violation and userMode are all 0. Every store bit and the fuse read as 0.
- R2: An accepted cmdReset sets curAddr to 0 on the next clock edge.
- R3: An accepted cmdRead sets curAddr to curAddr+1 and, on the same edge, loads dataOut with the bit at the new address.
- R4: An accepted cmdProg on a permitted address below 192 sets that bit to 1 and leaves every other bit and curAddr unchanged. Programming never clears a bit.
- R5: An accepted cmdErase on a permitted byte sets all 8 bits of byte curAddr/8 to 0 and leaves the other bytes unchanged.
- R6: In issuer mode (userMode=0), programming is permitted at addresses 0 to 191 and erasing is permitted on bytes 0 to 23. In user mode, only addresses 64 to 111 may be programmed, and only bytes 8 to 13 may be erased.
- R7: A cmdProg or cmdErase that is not permitted, including one at an address of 192 or above other than the fuse, changes no stored bit and does not raise busy. It sets violation, which then stays 1 until rstN.
- R8: A cmdProg at address 260 in issuer mode blows the fuse, and userMode becomes 1 and stays 1. A read at 260 returns the fuse bit. In user mode a cmdProg at 260 is treated as a violation.
- R9: An accepted program, erase or fuse blow raises busy on the next edge and holds it for exactly PROG_CYCLES cycles. Any command sampled while busy is 1 is ignored.
- R10: A read of any address of 192 or above other than 260 returns 0. curAddr saturates at 511: a cmdRead at 511 leaves it at 511.
- R11: When several strobes are high in one idle cycle, only one takes effect, in the priority order cmdReset, cmdRead, cmdProg, cmdErase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| cmdReset | input | 1 | Strobe: clear the address pointer |
| cmdRead | input | 1 | Strobe: advance the pointer and read a bit |
| cmdProg | input | 1 | Strobe: set the bit at the pointer |
| cmdErase | input | 1 | Strobe: clear the byte holding the pointer |
| dataOut | output | 1 | Bit returned by the last accepted read |
| curAddr | output | 9 | Current address pointer |
| busy | output | 1 | Program or erase time running, commands ignored |
| violation | output | 1 | Sticky flag for a blocked program or erase |
| userMode | output | 1 | Fuse blown, user rule set in force |

## Verification
Every strobe is captured by one clock edge. curAddr, dataOut, userMode and violation are all registered on that edge, so the bench drives a strobe at a falling edge, removes it at the next falling edge, and checks the results there, half a cycle after the capturing edge. busy rises on the same edge as an accepted write or clear and stays high for PROG_CYCLES cycles. The bench measures this by counting falling edges until busy drops, and it issues an extra command inside that window to show it is ignored. Stored contents are only visible through reads, so after each phase the bench walks the pointer from 1 to 260 and compares every returned bit with its own model.

// File: rtl/bitser_secmem_pkg.sv
package bitser_secmem_pkg;

  // Strobes passed from the command control to the storage datapath.
  typedef struct packed {
    logic rdLatch;   // load dataOut from the advanced address
    logic wrBit;     // set one bit at the current address
    logic erByte;    // clear the byte holding the current address
    logic fuseBlow;  // set the configuration fuse
  } strobe_t;

endpackage

// File: rtl/bitser_secmem_ctrl.sv
module bitser_secmem_ctrl
  import bitser_secmem_pkg::*;
#(
  parameter int MEM_BITS    = 192,
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 9,
  parameter int FUSE_ADDR   = 260,
  parameter int USER_LO     = 64,
  parameter int USER_HI     = 111,
  parameter int PROG_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdReset,
  input  logic              cmdRead,
  input  logic              cmdProg,
  input  logic              cmdErase,
  input  logic              fuseBlown,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output strobe_t           stb,
  output logic              busy,
  output logic              violation
);

  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0]  CNT_LOAD = CNT_W'(PROG_CYCLES);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;
  localparam logic [ADDR_W-1:0] LAST_BIT = ADDR_W'(MEM_BITS - 1);
  localparam logic [ADDR_W-1:0] FUSE_A   = ADDR_W'(FUSE_ADDR);
  localparam logic [ADDR_W-1:0] LO_A     = ADDR_W'(USER_LO);
  localparam logic [ADDR_W-1:0] HI_A     = ADDR_W'(USER_HI);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(BYTE_W - 1);

  logic [ADDR_W-1:0] addrQ, incAddr, byteBase, byteLast;
  logic [CNT_W-1:0]  cntQ;
  logic              violQ;
  logic              idle, inMem, isFuse;
  logic              progOk, fuseOk, eraseOk;
  logic              doReset, doRead, doProg, doErase;
  logic              blocked, startTimer;

  // Address decode and permission rules
  always_comb begin
    idle     = (cntQ == '0);
    incAddr  = (addrQ == ADDR_MAX) ? addrQ : addrQ + ADDR_ONE;
    inMem    = (addrQ <= LAST_BIT);
    isFuse   = (addrQ == FUSE_A);
    byteBase = addrQ & ~LOW_MASK;
    byteLast = byteBase | LOW_MASK;
    if (fuseBlown) begin
      progOk  = (addrQ >= LO_A) && (addrQ <= HI_A);
      eraseOk = inMem && (byteBase >= LO_A) && (byteLast <= HI_A);
    end else begin
      progOk  = inMem;
      eraseOk = inMem;
    end
    fuseOk = !fuseBlown && isFuse;
  end

  // Command priority: reset, read, program, erase
  always_comb begin
    doReset = idle && cmdReset;
    doRead  = idle && !cmdReset && cmdRead;
    doProg  = idle && !cmdReset && !cmdRead && cmdProg;
    doErase = idle && !cmdReset && !cmdRead && !cmdProg && cmdErase;

    stb.rdLatch  = doRead;
    stb.wrBit    = doProg && progOk;
    stb.fuseBlow = doProg && fuseOk;
    stb.erByte   = doErase && eraseOk;

    blocked    = (doProg && !progOk && !fuseOk) || (doErase && !eraseOk);
    startTimer = stb.wrBit || stb.fuseBlow || stb.erByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (doReset) begin
      addrQ <= '0;
    end else if (doRead) begin
      addrQ <= incAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (startTimer) begin
      cntQ <= CNT_LOAD;
    end else if (!idle) begin
      cntQ <= cntQ - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violQ <= 1'b0;
    end else if (blocked) begin
      violQ <= 1'b1;
    end
  end

  assign curAddr   = addrQ;
  assign rdAddr    = incAddr;
  assign busy      = !idle;
  assign violation = violQ;

endmodule

// File: rtl/bitser_secmem_dpath.sv
module bitser_secmem_dpath
  import bitser_secmem_pkg::*;
#(
  parameter int MEM_BITS  = 192,
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 9,
  parameter int FUSE_ADDR = 260
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              dataOut,
  output logic              fuseBlown
);

  localparam int NUM_BYTES = MEM_BITS / BYTE_W;
  localparam int BIT_W     = $clog2(BYTE_W);
  localparam int IDX_W     = ADDR_W - BIT_W;
  localparam int ADDR_SPAN = 2 ** ADDR_W;

  logic [MEM_BITS-1:0]  memBits;
  logic [ADDR_SPAN-1:0] flatBits;
  logic [IDX_W-1:0]     addrByte;
  logic [BYTE_W-1:0]    bitMask;
  logic                 fuseQ;
  logic                 dataQ;

  assign addrByte = addr[ADDR_W-1:BIT_W];
  assign bitMask  = BYTE_W'(1) << addr[BIT_W-1:0];

  // One register group per byte; erase clears it, program ORs one bit in.
  for (genvar g = 0; g < NUM_BYTES; g++) begin : gByte
    logic [BYTE_W-1:0] byteQ;
    logic              hit;
    assign hit = (addrByte == IDX_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        byteQ <= '0;
      end else if (stb.erByte && hit) begin
        byteQ <= '0;
      end else if (stb.wrBit && hit) begin
        byteQ <= byteQ | bitMask;
      end
    end
    assign memBits[g*BYTE_W +: BYTE_W] = byteQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fuseQ <= 1'b0;
    end else if (stb.fuseBlow) begin
      fuseQ <= 1'b1;
    end
  end

  // Whole address space view: store, zero gap, fuse
  always_comb begin
    flatBits                 = '0;
    flatBits[MEM_BITS-1:0]   = memBits;
    flatBits[FUSE_ADDR]      = fuseQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= 1'b0;
    end else if (stb.rdLatch) begin
      dataQ <= flatBits[rdAddr];
    end
  end

  assign dataOut   = dataQ;
  assign fuseBlown = fuseQ;

endmodule

// File: rtl/bitser_secmem.sv
module bitser_secmem
  import bitser_secmem_pkg::*;
#(
  parameter int MEM_BITS    = 192,
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 9,
  parameter int FUSE_ADDR   = 260,
  parameter int USER_LO     = 64,
  parameter int USER_HI     = 111,
  parameter int PROG_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdReset,
  input  logic              cmdRead,
  input  logic              cmdProg,
  input  logic              cmdErase,
  output logic              dataOut,
  output logic [ADDR_W-1:0] curAddr,
  output logic              busy,
  output logic              violation,
  output logic              userMode
);

  strobe_t           stb;
  logic [ADDR_W-1:0] rdAddr;
  logic              fuseBlown;

  bitser_secmem_ctrl #(
    .MEM_BITS(MEM_BITS), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W),
    .FUSE_ADDR(FUSE_ADDR), .USER_LO(USER_LO), .USER_HI(USER_HI),
    .PROG_CYCLES(PROG_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdReset(cmdReset), .cmdRead(cmdRead), .cmdProg(cmdProg), .cmdErase(cmdErase),
    .fuseBlown(fuseBlown),
    .curAddr(curAddr), .rdAddr(rdAddr), .stb(stb),
    .busy(busy), .violation(violation)
  );

  bitser_secmem_dpath #(
    .MEM_BITS(MEM_BITS), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .FUSE_ADDR(FUSE_ADDR)
  ) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .addr(curAddr), .rdAddr(rdAddr),
    .dataOut(dataOut), .fuseBlown(fuseBlown)
  );

  assign userMode = fuseBlown;

endmodule

// File: rtl/bitser_secmem_chk.sv
module bitser_secmem_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdReset,
  input logic              cmdRead,
  input logic              cmdProg,
  input logic              cmdErase,
  input logic [ADDR_W-1:0] curAddr,
  input logic              busy,
  input logic              violation,
  input logic              userMode
);

  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

  AST_RESET_CLEARS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReset && !busy) |=> (curAddr == '0)); // R2

  AST_READ_STEPS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRead && !cmdReset && !busy && curAddr != ADDR_MAX)
      |=> (curAddr == $past(curAddr) + ADDR_W'(1))); // R3

  AST_PROG_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdProg || cmdErase) && !cmdRead && !cmdReset && !busy) |=> $stable(curAddr)); // R4

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> violation); // R7

  AST_BLOCK_NO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(violation) |-> !busy); // R7

  AST_FUSE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    userMode |=> userMode); // R8

  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdProg || cmdErase)); // R9

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(curAddr)); // R9

  AST_ADDR_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    (curAddr == ADDR_MAX && cmdRead && !cmdReset && !busy) |=> (curAddr == ADDR_MAX)); // R10

endmodule

bind bitser_secmem bitser_secmem_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN),
  .cmdReset(cmdReset), .cmdRead(cmdRead), .cmdProg(cmdProg), .cmdErase(cmdErase),
  .curAddr(curAddr), .busy(busy), .violation(violation), .userMode(userMode)
);

// File: tb/bitser_secmem_test.sv
module bitser_secmem_test;

  localparam int CLK_PERIOD = 10;
  localparam int PCYC       = 3;
  localparam int NBITS      = 192;
  localparam int FUSE_A     = 260;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdReset = 1'b0, cmdRead = 1'b0, cmdProg = 1'b0, cmdErase = 1'b0;
  logic       dataOut, busy, violation, userMode;
  logic [8:0] curAddr;

  int nChecks = 0;
  int nFail   = 0;
  logic [NBITS-1:0] model = '0;
  logic fuseModel = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitser_secmem #(.PROG_CYCLES(PCYC)) uut (
    .clk(clk), .rstN(rstN),
    .cmdReset(cmdReset), .cmdRead(cmdRead), .cmdProg(cmdProg), .cmdErase(cmdErase),
    .dataOut(dataOut), .curAddr(curAddr), .busy(busy),
    .violation(violation), .userMode(userMode)
  );

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expBit(input int a);
    if (a < NBITS) return int'(model[a]);
    if (a == FUSE_A) return int'(fuseModel);
    return 0;
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic pulse(input logic r, input logic rd, input logic p, input logic e);
    cmdReset = r; cmdRead = rd; cmdProg = p; cmdErase = e;
    @(negedge clk);
    cmdReset = 1'b0; cmdRead = 1'b0; cmdProg = 1'b0; cmdErase = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic gotoAddr(input int a);
    pulse(1, 0, 0, 0);
    for (int i = 0; i < a; i++) pulse(0, 1, 0, 0);
  endtask

  task automatic sweep(input string req);
    pulse(1, 0, 0, 0);
    chk("R2", "pointer after reset", int'(curAddr), 0);
    for (int a = 1; a <= FUSE_A; a++) begin
      pulse(0, 1, 0, 0);
      chk("R3", "pointer after read", int'(curAddr), a);
      chk(req, $sformatf("bit %0d", a), int'(dataOut), expBit(a));
    end
  endtask

  task automatic progAt(input int a, input logic allowed, input string req);
    gotoAddr(a);
    pulse(0, 0, 1, 0);
    chk(req, $sformatf("busy after prog %0d", a), int'(busy), int'(allowed));
    chk("R4", "pointer kept by prog", int'(curAddr), a);
    if (allowed && a < NBITS) model[a] = 1'b1;
    waitIdle();
  endtask

  task automatic eraseAt(input int a, input logic allowed, input string req);
    gotoAddr(a);
    pulse(0, 0, 0, 1);
    chk(req, $sformatf("busy after erase %0d", a), int'(busy), int'(allowed));
    if (allowed) for (int b = 0; b < 8; b++) model[(a / 8) * 8 + b] = 1'b0;
    waitIdle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: run did not end");
    finishRun();
  end

  initial begin
    int n;
    int freeBit;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "curAddr", int'(curAddr), 0);
    chk("R1", "dataOut", int'(dataOut), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "violation", int'(violation), 0);
    chk("R1", "userMode", int'(userMode), 0);
    sweep("R1");

    // R4 R6 issuer mode: program a pattern across the whole store in one walk
    pulse(1, 0, 0, 0);
    for (int a = 0; a < NBITS; a++) begin
      if (((a * 5) % 7) < 3) begin
        pulse(0, 0, 1, 0);
        chk("R6", "issuer prog accepted", int'(busy), 1);
        model[a] = 1'b1;
        waitIdle();
        chk("R4", "pointer kept by prog", int'(curAddr), a);
      end
      if (a < NBITS - 1) pulse(0, 1, 0, 0);
    end
    sweep("R4");

    // R9 busy length and ignored command
    gotoAddr(40);
    pulse(0, 0, 1, 0);
    n = 0;
    while (busy) begin
      n++;
      pulse(0, 1, 0, 0);
    end
    model[40] = 1'b1;
    chk("R9", "busy cycles", n, PCYC);
    chk("R9", "read ignored while busy", int'(curAddr), 40);

    // R5 R6 issuer erase of a read-only-in-user byte
    eraseAt(20, 1'b1, "R6");
    eraseAt(130, 1'b1, "R6");
    sweep("R5");
    chk("R7", "no violation in issuer", int'(violation), 0);

    // R8 blow the fuse
    progAt(FUSE_A, 1'b1, "R8");
    fuseModel = 1'b1;
    chk("R8", "userMode set", int'(userMode), 1);
    chk("R8", "fuse blow is no violation", int'(violation), 0);

    // R7 blocked program of a clear read-only bit
    freeBit = 16;
    while (model[freeBit]) freeBit++;
    progAt(freeBit, 1'b0, "R7");
    chk("R7", "violation set", int'(violation), 1);

    // R6 user mode window
    progAt(64, 1'b1, "R6");
    progAt(111, 1'b1, "R6");
    progAt(112, 1'b0, "R6");
    progAt(63, 1'b0, "R6");
    progAt(150, 1'b0, "R6");
    eraseAt(75, 1'b1, "R5");
    eraseAt(14, 1'b0, "R7");
    eraseAt(115, 1'b0, "R7");
    progAt(FUSE_A, 1'b0, "R8");
    chk("R8", "userMode kept", int'(userMode), 1);
    progAt(200, 1'b0, "R7");
    eraseAt(200, 1'b0, "R7");
    chk("R7", "violation sticky", int'(violation), 1);

    // R11 priority
    gotoAddr(76);
    pulse(0, 1, 1, 0);
    chk("R11", "read beats prog: pointer", int'(curAddr), 77);
    chk("R11", "read beats prog: no busy", int'(busy), 0);
    gotoAddr(71);
    pulse(0, 0, 1, 1);
    chk("R11", "prog beats erase: busy", int'(busy), 1);
    model[71] = 1'b1;
    waitIdle();
    sweep("R6");

    // R10 saturation
    gotoAddr(511);
    chk("R10", "pointer at top", int'(curAddr), 511);
    pulse(0, 1, 0, 0);
    chk("R10", "pointer saturates", int'(curAddr), 511);
    chk("R10", "top reads zero", int'(dataOut), 0);
    pulse(1, 1, 1, 1);
    chk("R11", "reset beats all", int'(curAddr), 0);
    chk("R11", "reset beats all: no busy", int'(busy), 0);

    finishRun();
  end

endmodule